// File: doc/BRIEF.md
# Cyclic DMA Descriptor and Completion Report Rings

This block sits between software and the consumer side of one channel of a cyclic audio DMA engine. Software hands work to the engine through a four-entry descriptor ring. Each descriptor is built from four 32-bit writes to a single push register. The engine's fetch logic takes the oldest descriptor and makes it active. It then reports the bytes it moves, and a residue register counts down the bytes still owed on the active descriptor.

When a descriptor that asked for notification finishes, the block pushes a completion report into a second four-entry ring and raises a one-cycle done pulse. Software drains each report with four reads of a single pop register. Both rings publish a status word with slot pointers, full, empty and a sticky error bit. A control bit clears both rings so that a channel can be restarted from a known state.

Top module: `dmaring_top`

## Requirements
- R1: Register selectors on `sw_addr` are 0 descriptor push, 1 report pop, 2 descriptor status, 3 report status, 4 control, 5 residue. After reset both status words read 0x100, the residue reads 0, and `act_valid`, `desc_ready` and `desc_done` are low.
- R2: A descriptor is taken from four consecutive writes to the push register, in the order address low, address high, byte length, flags. The first three writes leave the descriptor status and `desc_ready` unchanged. The fourth write makes the entry visible.
- R3: A status word carries the write slot in bits 1:0, the read slot in bits 5:4, empty in bit 8, full in bit 9 and error in bit 10. A ring holds four entries. When the two slots are equal, the full and empty bits tell four entries from none.
- R4: Completing a fourth push word while the descriptor ring is full sets its error bit, drops the entry and leaves both slot pointers unchanged.
- R5: Writing a status register with bit 10 set clears that ring's error bit. Other status bits are not writable.
- R6: A `desc_load` pulse pops the head descriptor when the ring is non-empty and no descriptor is active. It then drives `act_addr` with {address high, address low} and sets the residue to the byte length. The pulse is ignored when the ring is empty or a descriptor is already active.
- R7: Each `xfer_valid` cycle lowers the residue by `xfer_bytes`, clipped at zero. The residue rises again when the next descriptor loads.
- R8: The active descriptor completes when its residue reaches zero. If flag bit 16 is set, one report entry is pushed and `desc_done` is high for exactly the cycle after the completing edge. Otherwise neither happens.
- R9: A report is read as four words from the pop register: total bytes moved since the last ring clear (low word, then high word), the descriptor length, and the descriptor flags. The entry is popped on the fourth read.
- R10: Reading the pop register while the report ring is empty returns 0, sets the report error bit and leaves both report pointers unchanged.
- R11: While control bit 0 is 1, both rings, the partial word counters, the error bits, the active descriptor, the residue and the byte total are held clear. Writing the bit back to 0 resumes normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_rd_en | input | 1 | Software register read strobe (reads of the pop register consume words) |
| sw_addr | input | 3 | Register selector |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Read data for the selected register, valid in the strobe cycle |
| desc_load | input | 1 | Engine request to take the head descriptor |
| desc_ready | output | 1 | A descriptor is waiting and none is active |
| act_valid | output | 1 | A descriptor is active |
| act_addr | output | 64 | Buffer address of the active descriptor |
| xfer_valid | input | 1 | The engine moved bytes this cycle |
| xfer_bytes | input | 32 | Bytes moved this cycle |
| desc_done | output | 1 | One-cycle pulse when a notifying descriptor completes |

## Verification
Writes, loads and transfers are presented for one cycle and take effect on that cycle's rising edge. Status, residue and `act_addr` therefore hold their new values from the next falling edge, and the bench samples them there. Read data is combinational, so the bench samples `sw_rdata` shortly after raising the read strobe, before the edge that advances the report word counter. `desc_done` is high during the single cycle after the completing edge. The bench samples it at the falling edge right after the final transfer, and checks that it stays low after every earlier transfer.

// File: rtl/dmaring_pkg.sv
package dmaring_pkg;
  localparam int unsigned GROUP_WORDS = 4;
  localparam int unsigned STAT_RD_LSB = 4;
  localparam int unsigned STAT_EMPTY  = 8;
  localparam int unsigned STAT_FULL   = 9;
  localparam int unsigned STAT_ERR    = 10;
  localparam int unsigned NOTIFY_BIT  = 16;
  localparam int unsigned CTRL_CLR    = 0;

  typedef enum logic [2:0] {
    SEL_DESC_PUSH = 3'd0,
    SEL_RPT_POP   = 3'd1,
    SEL_DESC_STAT = 3'd2,
    SEL_RPT_STAT  = 3'd3,
    SEL_CTRL      = 3'd4,
    SEL_RESIDUE   = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/ring_slots.sv
module ring_slots #(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned ENTRY_W = 128
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      push,
  input  logic [ENTRY_W-1:0]        push_data,
  input  logic                      pop,
  input  logic                      err_set,
  input  logic                      err_clr,
  output logic [ENTRY_W-1:0]        head,
  output logic [$clog2(DEPTH)-1:0]  wr_ptr,
  output logic [$clog2(DEPTH)-1:0]  rd_ptr,
  output logic                      full,
  output logic                      empty,
  output logic                      err
);
  // DEPTH is expected to be a power of two so pointers wrap naturally.
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic               full_q, full_d, err_q, err_d;
  logic [ENTRY_W-1:0] slot_q [DEPTH];
  logic               empty_w, push_ok, pop_ok;

  assign empty_w = (wr_q == rd_q) && !full_q;
  assign push_ok = push && !full_q && !clr;
  assign pop_ok  = pop && !empty_w && !clr;

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    full_d = full_q;
    err_d  = err_q;
    if (clr) begin
      wr_d   = '0;
      rd_d   = '0;
      full_d = 1'b0;
      err_d  = 1'b0;
    end else begin
      if (push_ok) wr_d = wr_q + PTR_W'(1);
      if (pop_ok)  rd_d = rd_q + PTR_W'(1);
      if (push_ok && !pop_ok && (wr_d == rd_q)) full_d = 1'b1;
      else if (pop_ok && !push_ok)              full_d = 1'b0;
      if (err_set || (push && full_q) || (pop && empty_w)) err_d = 1'b1;
      else if (err_clr)                                    err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      full_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      full_q <= full_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) slot_q[wr_q] <= push_data;
  end

  assign head   = slot_q[rd_q];
  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;
  assign full   = full_q;
  assign empty  = empty_w;
  assign err    = err_q;
endmodule

// File: rtl/word_gather.sv
module word_gather #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WORD_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      wr,
  input  logic [WORD_W-1:0]         wdata,
  output logic [WORDS*WORD_W-1:0]   group,
  output logic                      group_done
);
  localparam int unsigned CNT_W = $clog2(WORDS);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] held_q [WORDS-1];
  logic              last;

  assign last = (cnt_q == CNT_W'(WORDS - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (wr) cnt_d = last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (wr && !last && !clr) held_q[cnt_q] <= wdata;
  end

  for (genvar g = 0; g < WORDS - 1; g++) begin : g_held
    assign group[g*WORD_W +: WORD_W] = held_q[g];
  end
  assign group[(WORDS-1)*WORD_W +: WORD_W] = wdata;

  assign group_done = wr && last && !clr;
endmodule

// File: rtl/word_pick.sv
module word_pick #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WORD_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      rd,
  input  logic                      avail,
  input  logic [WORDS*WORD_W-1:0]   entry,
  output logic [WORD_W-1:0]         word,
  output logic                      pop
);
  localparam int unsigned CNT_W = $clog2(WORDS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last, take;

  assign last = (cnt_q == CNT_W'(WORDS - 1));
  assign take = rd && avail && !clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (take) cnt_d = last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign word = avail ? entry[cnt_q*WORD_W +: WORD_W] : '0;
  assign pop  = take && last;
endmodule

// File: rtl/active_desc.sv
module active_desc #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned NOTIFY_BIT = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  load_req,
  input  logic                  head_avail,
  input  logic [4*WORD_W-1:0]   head,
  input  logic                  xfer_valid,
  input  logic [WORD_W-1:0]     xfer_bytes,
  output logic                  load_fire,
  output logic                  act_valid,
  output logic [2*WORD_W-1:0]   act_addr,
  output logic [WORD_W-1:0]     residue,
  output logic                  rpt_push,
  output logic [4*WORD_W-1:0]   rpt_entry,
  output logic                  desc_done
);
  logic                act_q, act_d, done_q, done_d;
  logic [WORD_W-1:0]   res_q, res_d, len_q, len_d, flags_q, flags_d;
  logic [2*WORD_W-1:0] addr_q, addr_d, total_q, total_d, total_adv;
  logic [WORD_W-1:0]   moved;
  logic                stepping, finish;

  assign load_fire = load_req && head_avail && !act_q && !clr;
  assign stepping  = act_q && xfer_valid && !clr;
  assign moved     = (xfer_bytes >= res_q) ? res_q : xfer_bytes;
  assign finish    = stepping && (xfer_bytes >= res_q);
  assign total_adv = total_q + (2*WORD_W)'(moved);
  assign rpt_push  = finish && flags_q[NOTIFY_BIT];
  assign rpt_entry = {flags_q, len_q, total_adv};

  always_comb begin
    act_d   = act_q;
    res_d   = res_q;
    len_d   = len_q;
    flags_d = flags_q;
    addr_d  = addr_q;
    total_d = total_q;
    done_d  = rpt_push;
    if (clr) begin
      act_d   = 1'b0;
      res_d   = '0;
      total_d = '0;
    end else if (load_fire) begin
      act_d   = 1'b1;
      addr_d  = head[0 +: 2*WORD_W];
      len_d   = head[2*WORD_W +: WORD_W];
      res_d   = head[2*WORD_W +: WORD_W];
      flags_d = head[3*WORD_W +: WORD_W];
    end else if (stepping) begin
      res_d   = res_q - moved;
      total_d = total_adv;
      if (finish) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      res_q   <= '0;
      len_q   <= '0;
      flags_q <= '0;
      addr_q  <= '0;
      total_q <= '0;
      done_q  <= 1'b0;
    end else begin
      act_q   <= act_d;
      res_q   <= res_d;
      len_q   <= len_d;
      flags_q <= flags_d;
      addr_q  <= addr_d;
      total_q <= total_d;
      done_q  <= done_d;
    end
  end

  assign act_valid = act_q;
  assign act_addr  = addr_q;
  assign residue   = res_q;
  assign desc_done = done_q;
endmodule

// File: rtl/dmaring_top.sv
module dmaring_top
  import dmaring_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sw_wr_en,
  input  logic                  sw_rd_en,
  input  logic [2:0]            sw_addr,
  input  logic [WORD_W-1:0]     sw_wdata,
  output logic [WORD_W-1:0]     sw_rdata,
  input  logic                  desc_load,
  output logic                  desc_ready,
  output logic                  act_valid,
  output logic [2*WORD_W-1:0]   act_addr,
  input  logic                  xfer_valid,
  input  logic [WORD_W-1:0]     xfer_bytes,
  output logic                  desc_done
);
  localparam int unsigned PTR_W   = $clog2(DEPTH);
  localparam int unsigned ENTRY_W = GROUP_WORDS * WORD_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // control register
  logic ring_clr, ctrl_d;
  always_comb begin
    ctrl_d = ring_clr;
    if (sw_wr_en && (sw_addr == SEL_CTRL)) ctrl_d = sw_wdata[CTRL_CLR];
  end
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ring_clr <= 1'b0;
    else          ring_clr <= ctrl_d;
  end

  // descriptor side
  logic               desc_wr, desc_push, desc_full, desc_empty, desc_err, desc_err_clr;
  logic [ENTRY_W-1:0] desc_group, desc_head;
  logic [PTR_W-1:0]   desc_wp, desc_rp;
  logic               load_fire;

  assign desc_wr      = sw_wr_en && (sw_addr == SEL_DESC_PUSH);
  assign desc_err_clr = sw_wr_en && (sw_addr == SEL_DESC_STAT) && sw_wdata[STAT_ERR];

  word_gather #(.WORDS(GROUP_WORDS), .WORD_W(WORD_W)) gather_i (
    .clk(clk), .rst_n(rst_n_s), .clr(ring_clr), .wr(desc_wr), .wdata(sw_wdata),
    .group(desc_group), .group_done(desc_push)
  );

  ring_slots #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) desc_ring_i (
    .clk(clk), .rst_n(rst_n_s), .clr(ring_clr), .push(desc_push), .push_data(desc_group),
    .pop(load_fire), .err_set(1'b0), .err_clr(desc_err_clr), .head(desc_head),
    .wr_ptr(desc_wp), .rd_ptr(desc_rp), .full(desc_full), .empty(desc_empty), .err(desc_err)
  );

  // active descriptor and residue
  logic [WORD_W-1:0]  residue;
  logic               rpt_push;
  logic [ENTRY_W-1:0] rpt_entry;

  active_desc #(.WORD_W(WORD_W), .NOTIFY_BIT(NOTIFY_BIT)) act_i (
    .clk(clk), .rst_n(rst_n_s), .clr(ring_clr), .load_req(desc_load), .head_avail(!desc_empty),
    .head(desc_head), .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes), .load_fire(load_fire),
    .act_valid(act_valid), .act_addr(act_addr), .residue(residue), .rpt_push(rpt_push),
    .rpt_entry(rpt_entry), .desc_done(desc_done)
  );

  assign desc_ready = !desc_empty && !act_valid;

  // report side
  logic               rpt_rd, rpt_pop, rpt_full, rpt_empty, rpt_err, rpt_err_clr, rpt_underrun;
  logic [ENTRY_W-1:0] rpt_head;
  logic [PTR_W-1:0]   rpt_wp, rpt_rp;
  logic [WORD_W-1:0]  rpt_word;

  assign rpt_rd       = sw_rd_en && (sw_addr == SEL_RPT_POP);
  assign rpt_underrun = rpt_rd && rpt_empty;
  assign rpt_err_clr  = sw_wr_en && (sw_addr == SEL_RPT_STAT) && sw_wdata[STAT_ERR];

  word_pick #(.WORDS(GROUP_WORDS), .WORD_W(WORD_W)) pick_i (
    .clk(clk), .rst_n(rst_n_s), .clr(ring_clr), .rd(rpt_rd), .avail(!rpt_empty),
    .entry(rpt_head), .word(rpt_word), .pop(rpt_pop)
  );

  ring_slots #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) rpt_ring_i (
    .clk(clk), .rst_n(rst_n_s), .clr(ring_clr), .push(rpt_push), .push_data(rpt_entry),
    .pop(rpt_pop), .err_set(rpt_underrun), .err_clr(rpt_err_clr), .head(rpt_head),
    .wr_ptr(rpt_wp), .rd_ptr(rpt_rp), .full(rpt_full), .empty(rpt_empty), .err(rpt_err)
  );

  // status words and read mux
  logic [WORD_W-1:0] desc_stat, rpt_stat;
  always_comb begin
    desc_stat                           = '0;
    desc_stat[PTR_W-1:0]                = desc_wp;
    desc_stat[STAT_RD_LSB +: PTR_W]     = desc_rp;
    desc_stat[STAT_EMPTY]               = desc_empty;
    desc_stat[STAT_FULL]                = desc_full;
    desc_stat[STAT_ERR]                 = desc_err;
    rpt_stat                            = '0;
    rpt_stat[PTR_W-1:0]                 = rpt_wp;
    rpt_stat[STAT_RD_LSB +: PTR_W]      = rpt_rp;
    rpt_stat[STAT_EMPTY]                = rpt_empty;
    rpt_stat[STAT_FULL]                 = rpt_full;
    rpt_stat[STAT_ERR]                  = rpt_err;
  end

  always_comb begin
    sw_rdata = '0;
    unique case (sw_addr)
      SEL_RPT_POP:   sw_rdata = rpt_word;
      SEL_DESC_STAT: sw_rdata = desc_stat;
      SEL_RPT_STAT:  sw_rdata = rpt_stat;
      SEL_CTRL:      sw_rdata = WORD_W'(ring_clr);
      SEL_RESIDUE:   sw_rdata = residue;
      default:       sw_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmaring_chk.sv
module dmaring_chk #(
  parameter int unsigned PTR_W  = 2,
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ring_clr,
  input logic              desc_push,
  input logic              desc_full,
  input logic              desc_empty,
  input logic              desc_err,
  input logic [PTR_W-1:0]  desc_wp,
  input logic [PTR_W-1:0]  desc_rp,
  input logic              rpt_empty,
  input logic              rpt_err,
  input logic [PTR_W-1:0]  rpt_wp,
  input logic [PTR_W-1:0]  rpt_rp,
  input logic              rpt_underrun,
  input logic              load_fire,
  input logic              act_valid,
  input logic [WORD_W-1:0] residue,
  input logic              desc_done
);
  assert_full_empty_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_full && desc_empty));

  // R3: unequal slots mean the ring is neither full nor empty
  assert_slot_occupancy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wp != desc_rp) |-> (!desc_full && !desc_empty));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_push && desc_full && !ring_clr) |=> (desc_err && (desc_wp == $past(desc_wp))));

  assert_residue_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !load_fire && !ring_clr) |=> (residue <= $past(residue)));

  assert_done_has_report_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> !rpt_empty);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |=> !desc_done);

  assert_underrun_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_underrun && !ring_clr) |=> (rpt_err && $stable(rpt_wp) && $stable(rpt_rp)));

  assert_ring_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ring_clr |=> (desc_empty && rpt_empty && !act_valid && (residue == '0)));
endmodule

bind dmaring_top dmaring_chk #(.PTR_W(PTR_W), .WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n_s), .ring_clr(ring_clr), .desc_push(desc_push),
  .desc_full(desc_full), .desc_empty(desc_empty), .desc_err(desc_err),
  .desc_wp(desc_wp), .desc_rp(desc_rp), .rpt_empty(rpt_empty), .rpt_err(rpt_err),
  .rpt_wp(rpt_wp), .rpt_rp(rpt_rp), .rpt_underrun(rpt_underrun), .load_fire(load_fire),
  .act_valid(act_valid), .residue(residue), .desc_done(desc_done)
);

// File: tb/dmaring_tb.sv
module dmaring_top_tb_top;
  logic        clk, rst_n;
  logic        sw_wr_en, sw_rd_en;
  logic [2:0]  sw_addr;
  logic [31:0] sw_wdata, sw_rdata;
  logic        desc_load, desc_ready, act_valid, xfer_valid, desc_done;
  logic [63:0] act_addr;
  logic [31:0] xfer_bytes;

  int n_chk = 0;
  int n_bad = 0;

  dmaring_top dut_i (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_rd_en(sw_rd_en), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .desc_load(desc_load), .desc_ready(desc_ready),
    .act_valid(act_valid), .act_addr(act_addr), .xfer_valid(xfer_valid),
    .xfer_bytes(xfer_bytes), .desc_done(desc_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // rows: {length, chunk per transfer, flags}
  localparam logic [95:0] VEC [4] = '{
    {32'd64,  32'd16, 32'h0001_0000},
    {32'd100, 32'd32, 32'h0001_0005},
    {32'd48,  32'd48, 32'h0000_0003},
    {32'd8,   32'd64, 32'h0001_0000}
  };

  function automatic logic [31:0] stat(input int wp, input int rp, input bit f,
                                       input bit e, input bit er);
    return 32'(wp) | (32'(rp) << 4) | (32'(e) << 8) | (32'(f) << 9) | (32'(er) << 10);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    sw_wr_en = 1'b1; sw_addr = a; sw_wdata = d;
    @(negedge clk);
    sw_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    sw_rd_en = 1'b1; sw_addr = a;
    #1 d = sw_rdata;
    @(negedge clk);
    sw_rd_en = 1'b0;
  endtask

  task automatic push_desc(input logic [31:0] lo, input logic [31:0] hi,
                           input logic [31:0] len, input logic [31:0] fl);
    reg_wr(3'd0, lo); reg_wr(3'd0, hi); reg_wr(3'd0, len); reg_wr(3'd0, fl);
  endtask

  task automatic pulse_load();
    desc_load = 1'b1;
    @(negedge clk);
    desc_load = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] b);
    xfer_valid = 1'b1; xfer_bytes = b;
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    logic [63:0] total;
    sw_wr_en = 0; sw_rd_en = 0; sw_addr = 0; sw_wdata = 0;
    desc_load = 0; xfer_valid = 0; xfer_bytes = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    reg_rd(3'd2, d); chk("R1 desc status", d, 32'h100);
    reg_rd(3'd3, d); chk("R1 report status", d, 32'h100);
    reg_rd(3'd5, d); chk("R1 residue", d, 0);
    chk("R1 act_valid", act_valid, 0);
    chk("R1 desc_ready", desc_ready, 0);
    chk("R1 desc_done", desc_done, 0);

    // R2 partial descriptor stays hidden
    reg_wr(3'd0, 32'hA000_0000); reg_wr(3'd0, 32'h1); reg_wr(3'd0, 32'd40);
    reg_rd(3'd2, d); chk("R2 three words hidden", d, 32'h100);
    chk("R2 desc_ready after three words", desc_ready, 0);
    reg_wr(3'd0, 32'h0);
    reg_rd(3'd2, d); chk("R2 fourth word visible", d, stat(1, 0, 0, 0, 0));
    chk("R2 desc_ready", desc_ready, 1);

    // R3 fill to four entries
    for (int k = 0; k < 3; k++) push_desc(32'hB000_0000, 32'h0, 32'd16, 32'h0);
    reg_rd(3'd2, d); chk("R3 full with equal slots", d, stat(0, 0, 1, 0, 0));

    // R4 overflow
    push_desc(32'hC000_0000, 32'h0, 32'd16, 32'h0);
    reg_rd(3'd2, d); chk("R4 overflow sets error, slots kept", d, stat(0, 0, 1, 0, 1));

    // R5 write-one-to-clear
    reg_wr(3'd2, 32'h0000_0303);
    reg_rd(3'd2, d); chk("R5 zero in bit 10 keeps error", d, stat(0, 0, 1, 0, 1));
    reg_wr(3'd2, 32'h400);
    reg_rd(3'd2, d); chk("R5 error cleared", d, stat(0, 0, 1, 0, 0));

    // R6 load the first descriptor
    pulse_load();
    chk("R6 act_valid", act_valid, 1);
    chk("R6 act_addr", act_addr, 64'h1_A000_0000);
    reg_rd(3'd5, d); chk("R6 residue loaded", d, 32'd40);
    reg_rd(3'd2, d); chk("R6 head popped", d, stat(0, 1, 0, 0, 0));
    pulse_load();
    reg_rd(3'd2, d); chk("R6 load ignored while active", d, stat(0, 1, 0, 0, 0));
    xfer(32'd8);
    reg_rd(3'd5, d); chk("R7 residue after 8 bytes", d, 32'd32);

    // R11 ring clear while active
    reg_wr(3'd4, 32'h1);
    reg_rd(3'd4, d); chk("R11 control reads back", d, 32'h1);
    reg_wr(3'd4, 32'h0);
    reg_rd(3'd2, d); chk("R11 desc ring cleared", d, 32'h100);
    reg_rd(3'd5, d); chk("R11 residue cleared", d, 0);
    chk("R11 active cleared", act_valid, 0);

    // table: push, load, transfer, report
    total = 0;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] len, chunk, fl, rem, mv;
      bit ntf;
      len = VEC[i][95:64]; chunk = VEC[i][63:32]; fl = VEC[i][31:0];
      ntf = fl[16];
      push_desc(32'h8000_0000 + 32'(i) * 32'h400, 32'(i + 1), len, fl);
      reg_rd(3'd2, d); chk("R2 table push", d, stat((i + 1) % 4, i % 4, 0, 0, 0));
      pulse_load();
      chk("R6 table act_addr", act_addr, {32'(i + 1), 32'h8000_0000 + 32'(i) * 32'h400});
      reg_rd(3'd5, d); chk("R7 residue rises on load", d, len);
      rem = len;
      while (rem != 0) begin
        mv = (chunk < rem) ? chunk : rem;
        xfer(chunk);
        rem = rem - mv;
        total = total + 64'(mv);
        if (rem != 0) begin
          chk("R8 no done mid descriptor", desc_done, 0);
          reg_rd(3'd5, d); chk("R7 residue step", d, rem);
        end else begin
          chk("R8 done pulse", desc_done, ntf);
        end
      end
      @(negedge clk);
      chk("R8 done is one cycle", desc_done, 0);
      chk("R8 descriptor retired", act_valid, 0);
      reg_rd(3'd5, d); chk("R7 residue clipped at zero", d, 0);
      reg_rd(3'd3, d); chk("R8 report presence", 64'(d[8]), 64'(!ntf));
      if (ntf) begin
        reg_rd(3'd1, d); chk("R9 count low", d, total[31:0]);
        reg_rd(3'd1, d); chk("R9 count high", d, total[63:32]);
        reg_rd(3'd1, d); chk("R9 length", d, len);
        reg_rd(3'd1, d); chk("R9 flags", d, fl);
        reg_rd(3'd3, d); chk("R9 popped after fourth read", 64'(d[8]), 1);
      end
    end

    // R6 load on empty ring
    pulse_load();
    chk("R6 load ignored when empty", act_valid, 0);

    // R10 underrun: three reports went through, slots at 3
    reg_rd(3'd1, d); chk("R10 empty read data", d, 0);
    reg_rd(3'd3, d); chk("R10 error set, slots kept", d, stat(3, 3, 0, 1, 1));
    reg_wr(3'd3, 32'h400);
    reg_rd(3'd3, d); chk("R5 report error cleared", d, stat(3, 3, 0, 1, 0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule